// File: doc/BRIEF.md
# Configurable-Frame Asynchronous Serial Transmitter

This block takes a parallel word through a valid/ready handshake and sends it on one serial line as an asynchronous character. Each character has a low start bit, then 5 to 9 data bits with the least significant bit first, then an optional even or odd parity bit, and finally one or two high stop bits. The line rests high between characters. The format is chosen per character from configuration pins, which are captured together with the word when the handshake completes. This lets software or a neighbouring block change the format between characters.

Bit timing comes from an internal tick divider. The divider emits one enable every `TICK_DIV` clocks, and each serial bit lasts 16 such ticks. The divider restarts at every acceptance, so every bit of a character is exactly `16*TICK_DIV` clocks long. The handshake stays closed for the whole character. It reopens in the cycle after the last stop bit has been sent.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset and whenever no character is in progress, `tx_out` is 1 and `in_ready` is 1.
- R2: A word is accepted at a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle on, `tx_out` carries the start bit, which is 0.
- R3: After the start bit, the data bits follow with bit 0 of `in_data` first. The count is set by `cfg_len`: a value from 5 to 9 is the bit count, a value below 5 means 5, and a value above 9 means 9.
- R4: When `cfg_par_en` is 1, one parity bit follows the last data bit. With `cfg_par_odd` at 0 the count of ones over data and parity is even. With `cfg_par_odd` at 1 it is odd.
- R5: When `cfg_par_en` is 1 and the length resolves to 9, only 8 data bits are sent and `in_data[8]` is not sent.
- R6: The character ends with high stop bits: one when `cfg_two_stop` is 0, two when it is 1.
- R7: Every bit, including the start and stop bits, lasts exactly `16*TICK_DIV` clocks, and `tx_out` changes only at bit boundaries.
- R8: `in_ready` is 0 from the cycle after acceptance until the last stop bit ends. It returns to 1 in the cycle right after that, so a held `in_valid` starts the next character after one idle clock.
- R9: Changing `in_data` or the configuration pins after acceptance does not alter the character in progress.
- R10: `in_valid` asserted while a character is in progress is ignored: the current character is unchanged and no word is taken until `in_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Transmitter can take a word |
| in_data | input | 9 | Word to send, bit 0 first |
| cfg_len | input | 4 | Data bit count (clamped to 5..9) |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| tx_out | output | 1 | Serial line, idle high |

## Verification
Two functions can fall in the same cycle. The first is the end of the final stop bit, where `in_ready` reopens. The second is the handshake on a word that the source has held valid through the whole character. The bench provokes this overlap by keeping `in_valid` high with a different word during a character. It then checks that the running character is unaltered and that the line shows exactly one idle-high clock before the next start bit. A second overlap happens inside the length logic: parity enable and a requested length of 9 arrive together. The bench judges this case from the bit positions where the parity bit and the stop bit appear.

// File: rtl/uftx_pkg.sv
// Package: shared sizes, the captured frame type and the length rule.
// Assumes frames carry at most MAX_LEN data bits and at most two stop bits.
package uftx_pkg;

    localparam int MAX_LEN  = 9;
    localparam int MIN_LEN  = 5;
    localparam int LEN_W    = 4;
    localparam int FRAME_W  = 1 + MAX_LEN + 1 + 2;
    localparam int CNT_W    = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] bits;   // line levels, bit 0 sent first
        logic [CNT_W-1:0]   nbits;  // number of bit periods in frame
    } frame_t;

    // Resolve the requested length into the number of data bits sent.
    function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] req,
                                                 input logic par_en);
        logic [LEN_W-1:0] n;
        if (req < LEN_W'(MIN_LEN))
            n = LEN_W'(MIN_LEN);
        else if (req > LEN_W'(MAX_LEN))
            n = LEN_W'(MAX_LEN);
        else
            n = req;
        if (par_en && n == LEN_W'(MAX_LEN))
            n = LEN_W'(MAX_LEN - 1);
        return n;
    endfunction

endpackage

// File: rtl/uftx_tick_gen.sv
// Oversampling enable divider: pulses tick once every DIV clocks while run
// is high. Restart forces the phase to zero so the first tick lands DIV
// clocks after it. Assumes DIV >= 1.
module uftx_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);

    generate
        if (DIV == 1) begin : g_pass
            // Every clock is a tick when the divider is trivial.
            assign tick = run;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt;

            // Phase counter, held at zero while idle or on restart.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt <= '0;
                else if (restart || !run)
                    cnt <= '0;
                else if (cnt == LAST)
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end

            assign tick = run && (cnt == LAST);
        end
    endgenerate

endmodule

// File: rtl/uftx_framer.sv
// Frame builder: turns a word and the format pins into the full sequence
// of line levels and its length. Pure combinational; the engine captures
// its output at acceptance. Assumes the inputs are stable that cycle.
module uftx_framer
    import uftx_pkg::*;
(
    input  logic [MAX_LEN-1:0] data,
    input  logic [LEN_W-1:0]   len,
    input  logic               par_en,
    input  logic               par_odd,
    input  logic               two_stop,
    output frame_t             frame
);

    logic [LEN_W-1:0]   n;
    logic [FRAME_W-1:0] lv;
    logic               par;

    // Lay out start, data, parity and stop levels, LSB of data first.
    always_comb begin
        n   = eff_len(len, par_en);
        lv  = '1;
        lv[0] = 1'b0;
        par = par_odd;
        for (int i = 0; i < MAX_LEN; i++) begin
            if (i < int'(n)) begin
                lv[1 + i] = data[i];
                par       = par ^ data[i];
            end
        end
        if (par_en)
            lv[1 + int'(n)] = par;
    end

    // Count of bit periods: start + data + parity + stop(s).
    always_comb begin
        frame.bits  = lv;
        frame.nbits = CNT_W'(2) + CNT_W'(n) + CNT_W'(par_en) + CNT_W'(two_stop);
    end

endmodule

// File: rtl/uftx_engine.sv
// Shift engine: holds the captured frame, counts 16 ticks per bit and
// steps the line level at each bit boundary. Busy spans acceptance to the
// end of the last stop bit. Assumes accept is only raised while idle.
module uftx_engine
    import uftx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   accept,
    input  frame_t frm,
    input  logic   tick,
    output logic   busy,
    output logic   tx
);

    localparam int SUB_W = $clog2(OVS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

    logic [SUB_W-1:0]   sub;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   left;
    logic               bit_end;

    assign bit_end = busy && tick && (sub == SUB_LAST);

    // Tick counter within the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sub <= '0;
        else if (accept || bit_end)
            sub <= '0;
        else if (busy && tick)
            sub <= sub + 1'b1;
    end

    // Frame sequencing: load on accept, advance one level per bit end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            tx    <= 1'b1;
            shreg <= '1;
            left  <= '0;
        end else if (accept) begin
            busy  <= 1'b1;
            tx    <= frm.bits[0];
            shreg <= {1'b1, frm.bits[FRAME_W-1:1]};
            left  <= frm.nbits;
        end else if (bit_end) begin
            if (left == CNT_W'(1)) begin
                busy <= 1'b0;
                tx   <= 1'b1;
            end else begin
                tx    <= shreg[0];
                shreg <= {1'b1, shreg[FRAME_W-1:1]};
                left  <= left - 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_frame_tx.sv
// Top: valid/ready word intake, per-frame format capture and serial output.
// Each bit lasts OVS ticks of a divide-by-TICK_DIV enable.
// Assumes a synchronous active-low reset and a single clock domain.
module uart_frame_tx
    import uftx_pkg::*;
#(
    parameter int TICK_DIV = 4,
    parameter int OVS      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [MAX_LEN-1:0] in_data,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic               cfg_par_en,
    input  logic               cfg_par_odd,
    input  logic               cfg_two_stop,
    output logic               tx_out
);

    frame_t frm;
    logic   busy;
    logic   accept;
    logic   tick;

    // Handshake: take a word only while no frame is running.
    assign accept   = in_valid && !busy;
    assign in_ready = !busy;

    uftx_framer u_framer (
        .data     (in_data),
        .len      (cfg_len),
        .par_en   (cfg_par_en),
        .par_odd  (cfg_par_odd),
        .two_stop (cfg_two_stop),
        .frame    (frm)
    );

    uftx_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .restart (accept),
        .tick    (tick)
    );

    uftx_engine #(.OVS(OVS)) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .frm    (frm),
        .tick   (tick),
        .busy   (busy),
        .tx     (tx_out)
    );

endmodule

// File: rtl/uftx_checker.sv
// Checker: port-level timing properties of the transmitter. Keeps its own
// bit-phase counter so no deep $past is needed.
module uftx_checker #(
    parameter int TICK_DIV = 4,
    parameter int OVS      = 16
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic tx_out
);

    localparam int BITC = OVS * TICK_DIV;
    localparam int PW   = $clog2(BITC) + 1;

    logic [PW-1:0] ph;

    // Clock position inside the current bit, restarted at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph <= '0;
        else if (in_valid && in_ready)
            ph <= '0;
        else if (!in_ready)
            ph <= (ph == PW'(BITC - 1)) ? '0 : ph + 1'b1;
    end

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> tx_out); // R1
    AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!tx_out && !in_ready)); // R2
    AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && ph != '0) |-> $stable(tx_out)); // R7
    AST_READY_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> (ph == '0)); // R8
    AST_LAST_BIT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> $past(tx_out)); // R6

endmodule

bind uart_frame_tx uftx_checker #(.TICK_DIV(TICK_DIV), .OVS(OVS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .tx_out   (tx_out)
);

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;

    localparam int DIV = 4;
    localparam int B   = 16 * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [8:0] in_data = '0;
    logic [3:0] cfg_len = 4'd8;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       tx_out;

    int checks = 0;
    int fails  = 0;

    uart_frame_tx #(.TICK_DIV(DIV), .OVS(16)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .cfg_len      (cfg_len),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_two_stop (cfg_two_stop),
        .tx_out       (tx_out)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // Expected line levels from the requirements; returns bit-period count.
    function automatic int build_exp(input logic [8:0] d, input int len, input bit par,
                                     input bit odd, input bit two, output logic [15:0] e);
        int n;
        int idx;
        int ones;
        n = (len < 5) ? 5 : ((len > 9) ? 9 : len);
        if (par && n == 9) n = 8;
        e = '1;
        idx = 0;
        ones = 0;
        e[idx] = 1'b0; idx++;
        for (int i = 0; i < n; i++) begin
            e[idx] = d[i]; idx++;
            if (d[i]) ones++;
        end
        if (par) begin
            e[idx] = odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
            idx++;
        end
        idx++;
        if (two) idx++;
        return idx;
    endfunction

    // Send one word and check every bit. mode 0 plain, 1 disturb inputs
    // mid-frame, 2 hold in_valid high with word dn during the frame.
    task automatic run_frame(input logic [8:0] d, input int len, input bit par,
                             input bit odd, input bit two, input int mode,
                             input logic [8:0] dn, input string tag);
        logic [15:0] e;
        int nb;
        nb = build_exp(d, len, par, odd, two, e);
        while (!in_ready) begin @(posedge clk); #1; end
        @(negedge clk);
        in_data = d; cfg_len = 4'(len); cfg_par_en = par;
        cfg_par_odd = odd; cfg_two_stop = two; in_valid = 1'b1;
        @(posedge clk); #1;
        if (mode == 2) in_data = dn;
        else in_valid = 1'b0;
        for (int c = 0; c <= nb * B; c++) begin
            if (mode == 1 && c == 3) begin
                in_data = ~d; cfg_len = (len == 5) ? 4'd9 : 4'd5;
                cfg_par_en = !par; cfg_par_odd = !odd; cfg_two_stop = !two;
            end
            if (c < nb * B) begin
                if (c % B == 0 || c % B == B / 2 || c % B == B - 1)
                    check(tag, tx_out, e[c / B]);
                if (c % B == 0 || c == nb * B - 1)
                    check("R8 ready low in frame", in_ready, 1'b0);
                @(posedge clk); #1;
            end else begin
                check("R1 idle after stop", tx_out, 1'b1);
                check("R8 ready back after stop", in_ready, 1'b1);
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        check("R1 ready in reset", in_ready, 1'b1);
        check("R1 line in reset", tx_out, 1'b1);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
            if (i % 5 == 0) begin
                check("R1 idle line", tx_out, 1'b1);
                check("R1 idle ready", in_ready, 1'b1);
            end
        end
    endtask

    task automatic t_basic();
        run_frame(9'h0A5, 8, 0, 0, 0, 0, '0, "R2 R3 R7 8N1 0xA5");
        run_frame(9'h03C, 8, 0, 0, 0, 0, '0, "R2 R3 R7 8N1 0x3C");
    endtask

    task automatic t_lengths();
        run_frame(9'h015, 5, 0, 0, 0, 0, '0, "R3 len5");
        run_frame(9'h02B, 6, 0, 0, 0, 0, '0, "R3 len6");
        run_frame(9'h055, 7, 0, 0, 0, 0, '0, "R3 len7");
        run_frame(9'h1C3, 9, 0, 0, 0, 0, '0, "R3 len9");
        run_frame(9'h1EA, 3, 0, 0, 0, 0, '0, "R3 len3 clamps to 5");
        run_frame(9'h1EA, 12, 0, 0, 0, 0, '0, "R3 len12 clamps to 9");
    endtask

    task automatic t_parity();
        run_frame(9'h0B7, 8, 1, 0, 0, 0, '0, "R4 even parity len8");
        run_frame(9'h0B7, 8, 1, 1, 0, 0, '0, "R4 odd parity len8");
        run_frame(9'h000, 7, 1, 1, 0, 0, '0, "R4 odd parity zeros");
        run_frame(9'h041, 6, 1, 0, 1, 0, '0, "R4 R6 even parity two stops");
    endtask

    task automatic t_clamp();
        run_frame(9'h1FF, 9, 1, 0, 0, 0, '0, "R5 parity len9 sends 8");
        run_frame(9'h100, 9, 1, 1, 1, 0, '0, "R5 bit8 dropped odd");
    endtask

    task automatic t_stops();
        run_frame(9'h081, 8, 0, 0, 1, 0, '0, "R6 two stop bits");
    endtask

    task automatic t_midchange();
        run_frame(9'h0C6, 8, 1, 0, 0, 1, '0, "R9 inputs changed mid-frame");
        run_frame(9'h019, 5, 0, 1, 1, 1, '0, "R9 inputs changed len5");
    endtask

    task automatic t_backtoback();
        run_frame(9'h05A, 8, 0, 0, 0, 2, 9'h0F0, "R10 valid held during frame");
        run_frame(9'h0F0, 8, 0, 0, 0, 0, '0, "R8 back-to-back second word");
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_lengths();
        t_parity();
        t_clamp();
        t_stops();
        t_midchange();
        t_backtoback();
        report();
        $finish;
    end

endmodule